// File: doc/BRIEF.md
# Exception Return Decoder and Unstacker

This block sits beside the program counter write path of a small processor core. Every value written to the program counter is examined. An ordinary address passes straight through as a branch. A return code marks the end of an interrupt handler. Its upper bits are all ones, and its low bits select the mode to resume in, the stack to restore from and the kind of frame that was saved.

For a valid return code, the block reads the eight-word saved context from the selected stack through a single-word memory port with a ready handshake. It then presents the restored registers, the raised stack pointer, the target mode and the chosen stack. It pulses one signal that clears the active interrupt and a done strobe. Codes that use the reserved low bits wrongly, or that ask for a floating-point frame, are rejected with an error strobe, and all state is left as it was.

Top module: `exc_return_unstacker`

## Requirements
- R1: A program counter write accepted while idle, whose bits [31:5] are not all ones, gives a one-cycle `branch_valid` in the next cycle, with `branch_target` equal to the written value. No memory request is made.
- R2: For a valid return code, bit 2 selects the base stack pointer: 1 selects `psp_in` and 0 selects `msp_in`. The first memory read uses that base address.
- R3: The frame is read as eight words at base, base+4, and so on up to base+28, in this order: R0, R1, R2, R3, R12, LR, PC, status. `mem_addr` holds steady while `mem_req` is high and `mem_ready` is low.
- R4: In the cycle after the eighth word is accepted, `done` and `clr_active` are high for exactly one cycle, and `sp_out` equals base+32.
- R5: At `done`, `pc_out` holds the word read from base+24 and `status_out` holds the word from base+28. `r0_out` to `lr_out` hold the words from offsets 0, 4, 8, 12, 16 and 20.
- R6: At `done`, `thread_mode` equals bit 3 of the code (1 = thread, 0 = handler), and `psp_sel` equals bit 2.
- R7: A return code with bit 1 = 1 or bit 0 = 0 gives a one-cycle `err` in the next cycle, with `err_fp` low. No memory request is made, and `sp_out`, `pc_out`, `r0_out`, `thread_mode` and `psp_sel` keep their values.
- R8: A return code with correct bits 1 and 0 but bit 4 = 0 (a floating-point frame) gives `err` and `err_fp` together for one cycle. No memory request is made, and the same outputs keep their values.
- R9: A program counter write while `busy` is high is ignored. It gives no `branch_valid` and no `err`, and the frame in progress completes with the expected contents.
- R10: After reset, `busy`, `done`, `mem_req`, `err`, `branch_valid`, `sp_out` and `pc_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_wr_valid | input | 1 | A program counter write is offered |
| pc_wr_data | input | 32 | Value written to the program counter |
| msp_in | input | 32 | Current main stack pointer |
| psp_in | input | 32 | Current process stack pointer |
| mem_req | output | 1 | Read request to the stack memory |
| mem_addr | output | 32 | Read byte address |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Read accepted and data present this cycle |
| branch_valid | output | 1 | Ordinary branch strobe |
| branch_target | output | 32 | Branch destination |
| busy | output | 1 | Frame restore in progress |
| done | output | 1 | Restore complete strobe |
| clr_active | output | 1 | Clear the active interrupt strobe |
| err | output | 1 | Malformed or unsupported return code strobe |
| err_fp | output | 1 | Error cause is a floating-point frame request |
| thread_mode | output | 1 | Resume in thread mode |
| psp_sel | output | 1 | Restored from the process stack |
| sp_out | output | 32 | Stack pointer after the restore |
| r0_out | output | 32 | Restored R0 |
| r1_out | output | 32 | Restored R1 |
| r2_out | output | 32 | Restored R2 |
| r3_out | output | 32 | Restored R3 |
| r12_out | output | 32 | Restored R12 |
| lr_out | output | 32 | Restored link register |
| pc_out | output | 32 | Restored program counter |
| status_out | output | 32 | Restored status word |

## Verification
The assertions assume that the memory drives `mem_rdata` whenever it raises `mem_ready`, and that the stack pointer inputs stay steady between the write and the first read. The bench keeps to this by holding `msp_in` and `psp_in` constant for each return and by answering reads with a latency of zero to two cycles, drawn at random. It mixes return codes, ordinary addresses, malformed codes and writes injected during a restore, each checked against values the bench computes from the address-hashed memory contents.

// File: rtl/erd_pkg.sv
// Package for the exception return unstacker.
// It holds the frame layout constants, the decoded code fields and the
// sequencer state type. Frame layout is fixed by the resume protocol.
package erd_pkg;

    // Number of words in a saved context frame
    localparam int FRAME_WORDS = 8;
    // Position of the program counter word inside the frame
    localparam int FRM_PC      = 6;
    // Position of the status word inside the frame
    localparam int FRM_STATUS  = 7;
    // Low bits of a return code that carry fields rather than signature
    localparam int CODE_LOW    = 5;

    // Fields extracted from a program counter write
    typedef struct packed {
        logic is_code;    // signature bits all ones
        logic fields_ok;  // reserved bits carry their fixed values
        logic fp_ok;      // no floating-point frame requested
        logic thread;     // resume in thread mode
        logic psp;        // restore from the process stack
    } code_fields_t;

    // Pop sequencer states
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_POP  = 1'b1
    } pop_state_t;

endpackage

// File: rtl/erd_decode.sv
// Return code decoder.
// Purely combinational. It classifies a program counter write and extracts
// the mode, stack and frame type bits. It assumes that only bits below
// CODE_LOW carry fields and that all bits above them form the signature.
module erd_decode
    import erd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] value,
    output code_fields_t    fields
);

    // Split the write into signature and field bits
    always_comb begin
        fields.is_code   = &value[XLEN-1:CODE_LOW];
        fields.fields_ok = value[0] & ~value[1];
        fields.fp_ok     = value[4];
        fields.thread    = value[3];
        fields.psp       = value[2];
    end

endmodule

// File: rtl/erd_seq.sv
// Pop sequencer.
// On start it latches a base address and issues FRAME_WORDS single-word
// reads at ascending addresses. Each read is held until the memory answers
// with ready. It assumes that read data is valid in the same cycle as ready.
module erd_seq
    import erd_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4,
    parameter int NWORDS     = FRAME_WORDS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [XLEN-1:0]           base,
    input  logic                      mem_ready,
    output logic                      mem_req,
    output logic [XLEN-1:0]           mem_addr,
    output logic                      cap_en,
    output logic [$clog2(NWORDS)-1:0] cap_idx,
    output logic                      last,
    output logic                      busy
);

    localparam int              IDX_W    = $clog2(NWORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);
    localparam logic [XLEN-1:0]  STEP     = XLEN'(WORD_BYTES);

    pop_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [XLEN-1:0]   addr_q;

    // Handshake and capture strobes derived from the current state
    always_comb begin
        busy     = (state_q == ST_POP);
        mem_req  = busy;
        mem_addr = addr_q;
        cap_en   = busy & mem_ready;
        cap_idx  = idx_q;
        last     = cap_en & (idx_q == LAST_IDX);
    end

    // State, word index and read address advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            addr_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_POP;
                        idx_q   <= '0;
                        addr_q  <= base;
                    end
                end
                ST_POP: begin
                    if (cap_en) begin
                        addr_q <= addr_q + STEP;
                        idx_q  <= idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: a pending read keeps its address until it is answered
    a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R3: accepted reads that are not the last step the address by one word
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !last) |=> (mem_req && mem_addr == $past(mem_addr) + STEP));

    // R4: the sequencer returns to idle after the final word
    a_r4_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);

endmodule

// File: rtl/erd_frame.sv
// Frame register file.
// It holds one register per frame word. Each register loads the read data
// when the sequencer captures its index. It assumes that at most one index
// is captured per cycle.
module erd_frame
    import erd_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NWORDS = FRAME_WORDS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cap_en,
    input  logic [$clog2(NWORDS)-1:0]       cap_idx,
    input  logic [XLEN-1:0]                 cap_data,
    output logic [NWORDS-1:0][XLEN-1:0]     words
);

    localparam int IDX_W = $clog2(NWORDS);

    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        // Load one frame word when its index is captured
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (cap_en && cap_idx == IDX_W'(g)) begin
                words[g] <= cap_data;
            end
        end
    end

endmodule

// File: rtl/exc_return_unstacker.sv
// Exception return decoder and unstacker (top).
// It classifies program counter writes. Ordinary addresses leave as branch
// strobes. Malformed or floating-point return codes raise an error and leave
// all state untouched. Valid codes restore the eight-word frame from the
// chosen stack. It assumes that the stack pointer inputs are steady in the
// cycle of the write, and that writes offered while busy may be dropped.
module exc_return_unstacker
    import erd_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_wr_valid,
    input  logic [XLEN-1:0] pc_wr_data,
    input  logic [XLEN-1:0] msp_in,
    input  logic [XLEN-1:0] psp_in,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ready,
    output logic            branch_valid,
    output logic [XLEN-1:0] branch_target,
    output logic            busy,
    output logic            done,
    output logic            clr_active,
    output logic            err,
    output logic            err_fp,
    output logic            thread_mode,
    output logic            psp_sel,
    output logic [XLEN-1:0] sp_out,
    output logic [XLEN-1:0] r0_out,
    output logic [XLEN-1:0] r1_out,
    output logic [XLEN-1:0] r2_out,
    output logic [XLEN-1:0] r3_out,
    output logic [XLEN-1:0] r12_out,
    output logic [XLEN-1:0] lr_out,
    output logic [XLEN-1:0] pc_out,
    output logic [XLEN-1:0] status_out
);

    localparam int              NWORDS      = FRAME_WORDS;
    localparam int              IDX_W       = $clog2(NWORDS);
    localparam logic [XLEN-1:0] FRAME_BYTES = XLEN'(NWORDS * WORD_BYTES);

    code_fields_t                 fields;
    logic                         accept;
    logic                         start;
    logic [XLEN-1:0]              base_sel;
    logic                         cap_en;
    logic [IDX_W-1:0]             cap_idx;
    logic                         last;
    logic [NWORDS-1:0][XLEN-1:0]  words;
    logic                         pend_thread;
    logic                         pend_psp;
    logic [XLEN-1:0]              pend_base;

    erd_decode #(.XLEN(XLEN)) u_decode (
        .value  (pc_wr_data),
        .fields (fields)
    );

    // Write acceptance, restore start and base stack selection
    always_comb begin
        accept   = pc_wr_valid & ~busy;
        start    = accept & fields.is_code & fields.fields_ok & fields.fp_ok;
        base_sel = fields.psp ? psp_in : msp_in;
    end

    erd_seq #(
        .XLEN       (XLEN),
        .WORD_BYTES (WORD_BYTES),
        .NWORDS     (NWORDS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base      (base_sel),
        .mem_ready (mem_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .last      (last),
        .busy      (busy)
    );

    erd_frame #(
        .XLEN   (XLEN),
        .NWORDS (NWORDS)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_data (mem_rdata),
        .words    (words)
    );

    // Map frame positions onto the named register outputs
    always_comb begin
        r0_out     = words[0];
        r1_out     = words[1];
        r2_out     = words[2];
        r3_out     = words[3];
        r12_out    = words[4];
        lr_out     = words[5];
        pc_out     = words[FRM_PC];
        status_out = words[FRM_STATUS];
    end

    // Strobes, pending fields and the completion outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            branch_valid  <= 1'b0;
            branch_target <= '0;
            err           <= 1'b0;
            err_fp        <= 1'b0;
            done          <= 1'b0;
            clr_active    <= 1'b0;
            thread_mode   <= 1'b0;
            psp_sel       <= 1'b0;
            sp_out        <= '0;
            pend_thread   <= 1'b0;
            pend_psp      <= 1'b0;
            pend_base     <= '0;
        end else begin
            branch_valid <= 1'b0;
            err          <= 1'b0;
            err_fp       <= 1'b0;
            done         <= 1'b0;
            clr_active   <= 1'b0;
            if (accept && !fields.is_code) begin
                branch_valid  <= 1'b1;
                branch_target <= pc_wr_data;
            end else if (accept && !start) begin
                err    <= 1'b1;
                err_fp <= fields.fields_ok & ~fields.fp_ok;
            end
            if (start) begin
                pend_thread <= fields.thread;
                pend_psp    <= fields.psp;
                pend_base   <= base_sel;
            end
            if (last) begin
                done        <= 1'b1;
                clr_active  <= 1'b1;
                thread_mode <= pend_thread;
                psp_sel     <= pend_psp;
                sp_out      <= pend_base + FRAME_BYTES;
            end
        end
    end

    // R1: a branch strobe never carries a return code signature
    a_r1_branch_not_code: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> !(&branch_target[XLEN-1:CODE_LOW]));

    // R1: a branch strobe never comes with a memory request
    a_r1_branch_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> !mem_req);

    // R2: a started restore issues its first read at the chosen stack pointer
    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mem_req && mem_addr == $past(base_sel)));

    // R4: done and clear-active form one single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_clear_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> clr_active);

    // R7: an error strobe leaves memory untouched and the outputs as they were
    a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_req && !done && $stable(sp_out) && $stable(pc_out)));

    // R8: the floating-point cause only appears together with an error
    a_r8_fp_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_fp |-> err);

    // R9: writes offered while busy produce no branch and no error
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pc_wr_valid) |=> (!branch_valid && !err));

endmodule

// File: tb/sim_exc_return_unstacker.sv
module sim_exc_return_unstacker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_wr_valid = 1'b0;
    logic [31:0] pc_wr_data = '0;
    logic [31:0] msp_in = '0;
    logic [31:0] psp_in = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        branch_valid, busy, done, clr_active, err, err_fp;
    logic        thread_mode, psp_sel;
    logic [31:0] branch_target, sp_out;
    logic [31:0] r0_out, r1_out, r2_out, r3_out, r12_out, lr_out, pc_out, status_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat = 0;
    logic [31:0] exp_addr = '0;

    always #2.5 clk = ~clk;

    exc_return_unstacker u0 (
        .clk(clk), .rst_n(rst_n), .pc_wr_valid(pc_wr_valid), .pc_wr_data(pc_wr_data),
        .msp_in(msp_in), .psp_in(psp_in), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .branch_valid(branch_valid),
        .branch_target(branch_target), .busy(busy), .done(done), .clr_active(clr_active),
        .err(err), .err_fp(err_fp), .thread_mode(thread_mode), .psp_sel(psp_sel),
        .sp_out(sp_out), .r0_out(r0_out), .r1_out(r1_out), .r2_out(r2_out),
        .r3_out(r3_out), .r12_out(r12_out), .lr_out(lr_out), .pc_out(pc_out),
        .status_out(status_out)
    );

    // Stack memory contents as a hash of the address
    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    // Expected class: 0 branch, 1 valid return, 2 bad reserved bits, 3 fp frame
    function automatic int kind_of(input logic [31:0] v);
        if (!(&v[31:5])) return 0;
        if (v[1] || !v[0]) return 2;
        if (!v[4]) return 3;
        return 1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: answers each read after 0..2 cycles and checks the address order
    always @(negedge clk) begin
        cycles++;
        if (mem_req) begin
            if (lat == 0) begin
                chk(mem_addr == exp_addr, "R3 read address", mem_addr, exp_addr);
                mem_ready = 1'b1;
                mem_rdata = memfn(mem_addr);
                exp_addr  = exp_addr + 32'd4;
                lat = int'($urandom % 3);
            end else begin
                mem_ready = 1'b0;
                mem_rdata = 32'hDEAD_BEEF;
                lat--;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    task automatic do_branch(input logic [31:0] v);
        pc_wr_valid = 1'b1;
        pc_wr_data  = v;
        @(negedge clk);
        pc_wr_valid = 1'b0;
        chk(branch_valid == 1'b1, "R1 branch strobe", 32'(branch_valid), 32'd1);
        chk(branch_target == v, "R1 branch target", branch_target, v);
        chk(mem_req == 1'b0 && err == 1'b0, "R1 no request", 32'(mem_req), 32'd0);
        @(negedge clk);
        chk(branch_valid == 1'b0, "R1 strobe single cycle", 32'(branch_valid), 32'd0);
    endtask

    task automatic do_bad(input logic [31:0] v);
        logic [31:0] sp0, pc0, r00;
        logic        tm0, ps0;
        bit          fp;
        sp0 = sp_out; pc0 = pc_out; r00 = r0_out; tm0 = thread_mode; ps0 = psp_sel;
        fp = (kind_of(v) == 3);
        pc_wr_valid = 1'b1;
        pc_wr_data  = v;
        @(negedge clk);
        pc_wr_valid = 1'b0;
        if (fp) begin
            chk(err == 1'b1 && err_fp == 1'b1, "R8 fp frame error", {30'd0, err, err_fp}, 32'd3);
            chk(mem_req == 1'b0 && sp_out == sp0 && pc_out == pc0 && r0_out == r00,
                "R8 state unchanged", sp_out, sp0);
        end else begin
            chk(err == 1'b1 && err_fp == 1'b0, "R7 reserved bit error", {30'd0, err, err_fp}, 32'd2);
            chk(mem_req == 1'b0 && sp_out == sp0 && pc_out == pc0 && r0_out == r00,
                "R7 state unchanged", sp_out, sp0);
        end
        chk(thread_mode == tm0 && psp_sel == ps0 && busy == 1'b0 && branch_valid == 1'b0,
            "R7 mode and stack unchanged", {30'd0, thread_mode, psp_sel}, {30'd0, tm0, ps0});
        @(negedge clk);
        chk(err == 1'b0 && mem_req == 1'b0, "R7 error single cycle", 32'(err), 32'd0);
    endtask

    task automatic do_return(input logic [31:0] v, input logic [31:0] msp, input logic [31:0] psp,
                             input bit inject);
        logic [31:0] base;
        bit          seen;
        msp_in = msp;
        psp_in = psp;
        base = v[2] ? psp : msp;
        exp_addr = base;
        pc_wr_valid = 1'b1;
        pc_wr_data  = v;
        @(negedge clk);
        chk(busy == 1'b1 && mem_req == 1'b1, "R2 restore started", 32'(busy), 32'd1);
        chk(mem_addr == base, "R2 base stack", mem_addr, base);
        if (inject) begin
            pc_wr_data = $urandom;
            @(negedge clk);
            chk(branch_valid == 1'b0 && err == 1'b0, "R9 write ignored while busy",
                {30'd0, branch_valid, err}, 32'd0);
        end
        pc_wr_valid = 1'b0;
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            if (done) begin
                seen = 1;
                break;
            end
            @(negedge clk);
        end
        chk(seen, "R4 done reached", 32'(seen), 32'd1);
        if (seen) begin
            chk(clr_active == 1'b1, "R4 clear active", 32'(clr_active), 32'd1);
            chk(sp_out == base + 32'd32, "R4 stack pointer rise", sp_out, base + 32'd32);
            chk(r0_out == memfn(base), "R5 R0", r0_out, memfn(base));
            chk(r1_out == memfn(base + 4), "R5 R1", r1_out, memfn(base + 4));
            chk(r2_out == memfn(base + 8), "R5 R2", r2_out, memfn(base + 8));
            chk(r3_out == memfn(base + 12), "R5 R3", r3_out, memfn(base + 12));
            chk(r12_out == memfn(base + 16), "R5 R12", r12_out, memfn(base + 16));
            chk(lr_out == memfn(base + 20), "R5 LR", lr_out, memfn(base + 20));
            chk(pc_out == memfn(base + 24), "R5 PC", pc_out, memfn(base + 24));
            chk(status_out == memfn(base + 28), "R5 status", status_out, memfn(base + 28));
            chk(thread_mode == v[3], "R6 thread mode", 32'(thread_mode), 32'(v[3]));
            chk(psp_sel == v[2], "R6 stack select", 32'(psp_sel), 32'(v[2]));
            @(negedge clk);
            chk(done == 1'b0 && clr_active == 1'b0 && busy == 1'b0, "R4 done single cycle",
                {30'd0, done, clr_active}, 32'd0);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(busy == 0 && done == 0 && mem_req == 0 && err == 0 && branch_valid == 0,
            "R10 reset strobes", {27'd0, busy, done, mem_req, err, branch_valid}, 32'd0);
        chk(sp_out == 0 && pc_out == 0, "R10 reset values", sp_out | pc_out, 32'd0);

        // Directed corners
        do_branch(32'h0800_1234);
        do_branch(32'hFFFF_FFD9);                            // R1: bit 5 clear
        do_return(32'hFFFF_FFF9, 32'h2001_FFC8, 32'h2000_8000, 0); // thread, main stack
        do_return(32'hFFFF_FFFD, 32'h2001_FFC8, 32'h2000_8000, 0); // thread, process stack
        do_return(32'hFFFF_FFF1, 32'h1000_0040, 32'h3000_0000, 1); // handler, main stack
        do_return(32'hFFFF_FFF5, 32'h1000_0040, 32'hFFFF_FFF0, 0); // R4: pointer wraps
        do_bad(32'hFFFF_FFFB);                               // R7: bit 1 set
        do_bad(32'hFFFF_FFF8);                               // R7: bit 0 clear
        do_bad(32'hFFFF_FFE9);                               // R8: bit 4 clear
        do_bad(32'hFFFF_FFEB);                               // R7: reserved error wins

        // Random mix
        for (int n = 0; n < 60; n++) begin
            int sel;
            sel = int'($urandom % 4);
            if (sel == 0) begin
                v = $urandom;
                if (&v[31:5]) v[5] = 1'b0;
                do_branch(v);
            end else if (sel == 3) begin
                v = {27'h7FF_FFFF, $urandom_range(0, 31)[4:0]};
                if (kind_of(v) == 1) v[0] = 1'b0;
                do_bad(v);
            end else begin
                v = {27'h7FF_FFFF, 1'b1, $urandom_range(0, 1)[0], $urandom_range(0, 1)[0], 2'b01};
                do_return(v, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
                          ($urandom % 2) == 1);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule